// File: doc/BRIEF.md
# Processor Reset Burst Monitor

This block sits beside a processor and watches its active-low reset line. While the processor is running or suspended, it counts the rising edges of that line. When a complete reset burst has been seen, it raises a one-cycle "chipset reset" notification for the rest of the system. The burst is complete in one of two cases: the expected number of edges has arrived, or no further edge has come within a timeout window that restarts on every edge. A burst that ends with an unexpected number of edges is reported on a mismatch level.

The block also carries out warm resets on request. A command drives the power controller's reset-input line low for a set number of millisecond ticks and then releases it. The block then waits a bounded time for the processor reset line to go low. If the line never goes low, the block raises a one-cycle cold-reset request. All durations are counted in ticks of an external 1 ms strobe. The reset line passes through a flop synchronizer before any logic uses it.

Top module: `rst_burst_monitor`

## Requirements
- R1: After reset, `resin_n_o` is 1 and `notify_o`, `cold_req_o` and `mismatch_o` are 0.
- R2: A rising edge of `ap_rst_n_i` is counted only when `ap_active_i` is 1 in the cycle the synchronized edge is seen. Edges while `ap_active_i` is 0 never lead to a notification.
- R3: When the counted edges reach `EXP_EDGES` (default 3), `notify_o` is 1 for exactly one cycle. With the default two-stage synchronizer, it goes high after the third clock edge that follows the input's rise.
- R4: With fewer than `EXP_EDGES` edges counted, each counted edge restarts a window of `EDGE_TMO_MS` ticks. `notify_o` pulses on the tick that ends the window.
- R5: At each notification, `mismatch_o` becomes 1 if the count differed from `EXP_EDGES` and 0 otherwise. It holds that value until the next notification.
- R6: The edge count returns to zero at every notification, so the next burst counts from zero.
- R7: A `warm_cmd_i` pulse while idle drives `resin_n_o` low from the next cycle. The line is released on the `PULSE_MS`-th tick after that.
- R8: After release, if the synchronized reset line is seen low before the check window ends, no cold request is issued.
- R9: If the reset line stays high for `CHECK_MS` ticks after release, `cold_req_o` pulses for one cycle.
- R10: A `warm_cmd_i` that arrives while a pulse or check is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_rst_n_i | input | 1 | Processor reset line, active low, asynchronous |
| ap_active_i | input | 1 | 1 while the processor is in the run or suspend state |
| warm_cmd_i | input | 1 | One-cycle warm reset command |
| tick_ms_i | input | 1 | One-cycle strobe every millisecond |
| resin_n_o | output | 1 | Reset-input line to the power controller, active low |
| notify_o | output | 1 | One-cycle chipset-reset notification |
| cold_req_o | output | 1 | One-cycle cold-reset request |
| mismatch_o | output | 1 | Last burst had an unexpected edge count |

## Verification
The bench builds the block with `EXP_EDGES=3` and two synchronizer stages. It shortens the windows to `EDGE_TMO_MS=6`, `PULSE_MS=3` and `CHECK_MS=5`, and issues a tick every fourth cycle. With these values the timeout expiry, edge gaps shorter than the window that exercise the restart, and the full warm-reset sequence with both a success and a failure all fit in a few hundred cycles. A behavioural model predicts all four outputs on every clock, and the bench adds directed counts of notifications and cold requests per scenario.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   typedef enum logic [1:0] {
      WR_IDLE  = 2'd0,
      WR_PULSE = 2'd1,
      WR_CHECK = 2'd2
   } wr_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rbm_sync.sv
module rbm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rbm_burst_counter.sv
module rbm_burst_counter #(
   parameter int EXP_EDGES   = 3,
   parameter int EDGE_TMO_MS = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic active_i,
   input  logic tick_i,
   output logic notify_o,
   output logic mismatch_o
);
   localparam int CW = $clog2(EXP_EDGES + 1);
   localparam int TW = $clog2(EDGE_TMO_MS + 1);

   logic [CW-1:0] cnt_q;
   logic [TW-1:0] tmr_q;
   logic          pend_q, notify_q, mis_q;
   logic [CW-1:0] cnt_inc;
   logic          counted;

   assign counted = rise_i & active_i;
   assign cnt_inc = cnt_q + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         tmr_q    <= '0;
         pend_q   <= 1'b0;
         notify_q <= 1'b0;
         mis_q    <= 1'b0;
      end else begin
         notify_q <= 1'b0;
         if (counted) begin
            if (cnt_inc >= CW'(EXP_EDGES)) begin
               notify_q <= 1'b1;
               mis_q    <= (cnt_inc != CW'(EXP_EDGES));
               cnt_q    <= '0;
               pend_q   <= 1'b0;
            end else begin
               cnt_q    <= cnt_inc;
               tmr_q    <= TW'(EDGE_TMO_MS);
               pend_q   <= 1'b1;
            end
         end else if (pend_q && tick_i) begin
            if (tmr_q == TW'(1)) begin
               notify_q <= 1'b1;
               mis_q    <= (cnt_q != CW'(EXP_EDGES));
               cnt_q    <= '0;
               pend_q   <= 1'b0;
            end else begin
               tmr_q    <= tmr_q - TW'(1);
            end
         end
      end
   end

   assign notify_o   = notify_q;
   assign mismatch_o = mis_q;

   // R3: the notification never lasts more than one cycle
   p_notify_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      notify_q |=> !notify_q);
   // R5: the mismatch level moves only together with a notification
   p_mismatch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mis_q) |-> notify_q);
   // R6: the count never stays at or above the expected value
   p_cnt_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
      notify_q |-> cnt_q == '0);
   // R4: a running window is within its bounds
   p_tmr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (tmr_q != '0 && tmr_q <= TW'(EDGE_TMO_MS)));
endmodule

// File: rtl/rbm_warm_seq.sv
module rbm_warm_seq
   import rbm_pkg::*;
#(
   parameter int PULSE_MS = 20,
   parameter int CHECK_MS = 350
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_i,
   input  logic tick_i,
   input  logic lvl_i,
   output logic resin_n_o,
   output logic cold_req_o
);
   localparam int TW = $clog2(max_of(PULSE_MS, CHECK_MS) + 1);

   wr_state_e     st_q;
   logic [TW-1:0] tmr_q;
   logic          cold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WR_IDLE;
         tmr_q  <= '0;
         cold_q <= 1'b0;
      end else begin
         cold_q <= 1'b0;
         unique case (st_q)
            WR_IDLE: begin
               if (cmd_i) begin
                  st_q  <= WR_PULSE;
                  tmr_q <= TW'(PULSE_MS);
               end
            end
            WR_PULSE: begin
               if (tick_i) begin
                  if (tmr_q == TW'(1)) begin
                     st_q  <= WR_CHECK;
                     tmr_q <= TW'(CHECK_MS);
                  end else begin
                     tmr_q <= tmr_q - TW'(1);
                  end
               end
            end
            WR_CHECK: begin
               if (!lvl_i) begin
                  st_q <= WR_IDLE;
               end else if (tick_i) begin
                  if (tmr_q == TW'(1)) begin
                     cold_q <= 1'b1;
                     st_q   <= WR_IDLE;
                  end else begin
                     tmr_q <= tmr_q - TW'(1);
                  end
               end
            end
            default: st_q <= WR_IDLE;
         endcase
      end
   end

   assign resin_n_o  = (st_q != WR_PULSE);
   assign cold_req_o = cold_q;

   // R9: a cold request is a single-cycle pulse
   p_cold_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cold_q |=> !cold_q);
   // R7: the reset-input line only falls after a command
   p_resin_fall_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resin_n_o) |-> $past(cmd_i));
   // R8: a cold request only follows a reset line still seen high
   p_cold_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cold_q |-> (resin_n_o && $past(lvl_i)));
endmodule

// File: rtl/rst_burst_monitor.sv
module rst_burst_monitor #(
   parameter int EXP_EDGES   = 3,
   parameter int EDGE_TMO_MS = 450,
   parameter int PULSE_MS    = 20,
   parameter int CHECK_MS    = 350,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ap_rst_n_i,
   input  logic ap_active_i,
   input  logic warm_cmd_i,
   input  logic tick_ms_i,
   output logic resin_n_o,
   output logic notify_o,
   output logic cold_req_o,
   output logic mismatch_o
);
   generate
      if (EXP_EDGES < 2) begin : g_bad_exp
         $error("EXP_EDGES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (EDGE_TMO_MS < 1 || PULSE_MS < 1 || CHECK_MS < 1) begin : g_bad_tmo
         $error("all windows need at least one tick");
      end
   endgenerate

   logic line_lvl, line_rise;

   rbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (ap_rst_n_i),
      .lvl_o  (line_lvl),
      .rise_o (line_rise)
   );

   rbm_burst_counter #(.EXP_EDGES(EXP_EDGES), .EDGE_TMO_MS(EDGE_TMO_MS)) burst_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (line_rise),
      .active_i   (ap_active_i),
      .tick_i     (tick_ms_i),
      .notify_o   (notify_o),
      .mismatch_o (mismatch_o)
   );

   rbm_warm_seq #(.PULSE_MS(PULSE_MS), .CHECK_MS(CHECK_MS)) warm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (warm_cmd_i),
      .tick_i     (tick_ms_i),
      .lvl_i      (line_lvl),
      .resin_n_o  (resin_n_o),
      .cold_req_o (cold_req_o)
   );

   // R2: no notification can come while the processor is not active and no window runs
   p_notify_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      notify_o |-> ($past(ap_active_i) || $past(tick_ms_i)));
endmodule

// File: tb/rst_burst_monitor_tb_top.sv
module rst_burst_monitor_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int EXP  = 3;
   localparam int TMO  = 6;
   localparam int PLS  = 3;
   localparam int CHK  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ap_rst_n = 1'b1;
   logic active = 1'b0;
   logic warm_cmd = 1'b0;
   logic tick = 1'b0;
   logic resin_n, notify, cold_req, mismatch;

   int total = 0;
   int bad = 0;
   int n_notify = 0;
   int n_cold = 0;
   bit run_cmp = 0;

   rst_burst_monitor #(
      .EXP_EDGES(EXP), .EDGE_TMO_MS(TMO), .PULSE_MS(PLS), .CHECK_MS(CHK), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ap_rst_n_i(ap_rst_n), .ap_active_i(active),
      .warm_cmd_i(warm_cmd), .tick_ms_i(tick), .resin_n_o(resin_n),
      .notify_o(notify), .cold_req_o(cold_req), .mismatch_o(mismatch)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit line_hist[$] = '{1, 1, 1};
   int m_cnt = 0, m_tmr = 0, m_wt = 0, m_ws = 0;
   bit m_pend = 0;
   bit e_notify = 0, e_mis = 0, e_cold = 0, e_resin = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         line_hist = '{1, 1, 1};
         m_cnt = 0; m_tmr = 0; m_pend = 0; m_ws = 0; m_wt = 0;
         e_notify = 0; e_mis = 0; e_cold = 0; e_resin = 1;
      end else begin
         bit seen_lvl, seen_rise;
         seen_lvl  = line_hist[1];
         seen_rise = line_hist[1] && !line_hist[2];
         e_notify = 0;
         if (seen_rise && active) begin
            if (m_cnt + 1 >= EXP) begin
               e_notify = 1; e_mis = (m_cnt + 1 != EXP); m_cnt = 0; m_pend = 0;
            end else begin
               m_cnt++; m_tmr = TMO; m_pend = 1;
            end
         end else if (m_pend && tick) begin
            if (m_tmr == 1) begin
               e_notify = 1; e_mis = (m_cnt != EXP); m_cnt = 0; m_pend = 0;
            end else m_tmr--;
         end
         e_cold = 0;
         if (m_ws == 0) begin
            if (warm_cmd) begin m_ws = 1; m_wt = PLS; end
         end else if (m_ws == 1) begin
            if (tick) begin
               if (m_wt == 1) begin m_ws = 2; m_wt = CHK; end
               else m_wt--;
            end
         end else begin
            if (!seen_lvl) m_ws = 0;
            else if (tick) begin
               if (m_wt == 1) begin e_cold = 1; m_ws = 0; end
               else m_wt--;
            end
         end
         e_resin = (m_ws != 1);
         void'(line_hist.pop_back());
         line_hist.push_front(ap_rst_n);
      end
   end

   always @(negedge clk) begin
      if (run_cmp) begin
         chk("R3 notify", notify, e_notify);
         chk("R5 mismatch", mismatch, e_mis);
         chk("R7 resin", resin_n, e_resin);
         chk("R9 cold", cold_req, e_cold);
         if (notify) n_notify++;
         if (cold_req) n_cold++;
      end
   end

   initial begin : tick_gen
      int c = 0;
      forever begin
         @(negedge clk);
         c++;
         tick = (c % 4 == 0);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic line_pulse(input int low_cyc, input int gap);
      @(negedge clk); ap_rst_n = 1'b0;
      idle(low_cyc);
      ap_rst_n = 1'b1;
      idle(gap);
   endtask

   task automatic send_warm();
      @(negedge clk); warm_cmd = 1'b1;
      @(negedge clk); warm_cmd = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int base;
      idle(3);
      // R1: reset state
      chk("R1 resin", resin_n, 1);
      chk("R1 notify", notify, 0);
      chk("R1 cold", cold_req, 0);
      chk("R1 mismatch", mismatch, 0);
      rst_n = 1'b1;
      run_cmp = 1;
      idle(4);

      // R2: edges while inactive are ignored
      base = n_notify;
      repeat (3) line_pulse(2, 4);
      idle(40);
      chk("R2 no notify inactive", n_notify - base, 0);
      chk("R2 mismatch untouched", mismatch, 0);

      // R3: full burst notifies at once
      active = 1'b1;
      base = n_notify;
      repeat (3) line_pulse(2, 3);
      idle(3);
      chk("R3 burst notify", n_notify - base, 1);
      chk("R5 mismatch clear", mismatch, 0);

      // R4: single edge notifies after the window
      base = n_notify;
      line_pulse(2, 10);
      chk("R4 not yet", n_notify - base, 0);
      idle(30);
      chk("R4 timeout notify", n_notify - base, 1);
      chk("R5 mismatch set", mismatch, 1);

      // R4: window restarts on each edge (gap shorter than window)
      base = n_notify;
      line_pulse(2, 16);
      line_pulse(2, 16);
      chk("R4 restart holds", n_notify - base, 0);
      idle(20);
      chk("R4 restart notify", n_notify - base, 1);

      // R6: count cleared, fresh burst completes
      base = n_notify;
      repeat (3) line_pulse(2, 3);
      idle(3);
      chk("R6 fresh burst", n_notify - base, 1);
      chk("R5 mismatch back", mismatch, 0);

      // R7/R9/R10: warm reset without response, second command ignored
      base = n_cold;
      send_warm();
      chk("R7 resin low", resin_n, 0);
      idle(2);
      send_warm();
      idle(60);
      chk("R9 one cold", n_cold - base, 1);
      chk("R10 extra cmd ignored", resin_n, 1);

      // R8: warm reset answered by the processor
      base = n_cold;
      send_warm();
      while (!resin_n) @(negedge clk);
      idle(2);
      ap_rst_n = 1'b0;
      idle(6);
      ap_rst_n = 1'b1;
      idle(60);
      chk("R8 no cold", n_cold - base, 0);

      idle(5);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule